// File: doc/BRIEF.md
# SPI Serial Memory Command Front End

This block is the slave-side command interpreter placed in front of a byte-wide non-volatile array of 2^ADDR_W words, 32768 by default. It brings the serial pins (select, clock, data in, pause and write-protect) into the system clock domain. It shifts in an eight-bit opcode and recognises six commands: array read, array write, write enable, write disable, status read and status write. The array commands are followed by a two-byte address.

Read data leaves on a serial output with its own output-enable, so the pad ring can build the tri-state driver. Array reads go to an external synchronous memory with one cycle of read latency. The block fetches each byte before its first bit is needed. Write data bytes, status bytes and the enable and disable requests leave as single-cycle pulses toward the page-programming block and the protection block. Those blocks in turn report a busy flag and the current status byte back to this one.

A pause input freezes a transfer in mid-byte. While the programming cycle is busy the front end answers only the status read. Any opcode it does not recognise makes it silent until the select line has gone high and then low again.

Top module: `spi_mem_front`

## Requirements
- R1: After reset, and whenever the select input is high, `so_oe` is low, SI is ignored and no request pulse is produced. A command starts only after select falls.
- R2: The opcode is taken MSB first on rising serial-clock edges. Bits 7..4 must be zero and bit 3 is ignored. Bits 2..0 select the command: 3'b011 array read, 3'b010 array write, 3'b110 write enable, 3'b100 write disable, 3'b101 status read, 3'b001 status write. Write enable and write disable each give exactly one pulse, `wren_pulse` or `wrdi_pulse`, and later bits in the same selection have no effect.
- R3: An opcode with a non-zero upper nibble, or with low bits 3'b000 or 3'b111, gives no request pulse and keeps `so_oe` low for the rest of that selection. A new selection is decoded normally.
- R4: Array read and array write take 16 address bits MSB first. The top bit is ignored and the low 15 bits form the word address. For a read, the first data byte appears on `so_data` MSB first. `so_oe` rises at the falling edge that follows the last address bit, and each later bit changes on a falling edge.
- R5: A read keeps streaming bytes from consecutive addresses. After address 0x7FFF it continues at 0x0000.
- R6: During the data phase of a read, the value on SI has no effect on the data returned.
- R7: Each complete data byte of an array write gives one `wr_byte_valid` pulse carrying the captured address and the byte. When select rises, `wr_commit` pulses once, but only if at least one byte was received and the bit count stands on a byte boundary.
- R8: A status write presents its byte on `sr_data`. It gives one `sr_commit` pulse when select rises on a byte boundary after that byte.
- R9: A status read returns `status_in` MSB first, and keeps returning it for as long as clocking continues. While `prog_busy` is high it returns 0xFF instead.
- R10: While `prog_busy` is high, every opcode other than status read is treated like an unrecognised one: no request pulses and no output.
- R11: When the pause input goes low while the serial clock is low, the transfer freezes. Clock edges are ignored and `so_oe` is low. When the pause input returns high while the clock is low, the transfer continues from the same bit.
- R12: `wp_n_sync` follows the write-protect pin through the input synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Transfer pause, active low |
| wp_n | input | 1 | Write-protect pin |
| prog_busy | input | 1 | Programming cycle in progress |
| status_in | input | 8 | Status byte from the protection block |
| mem_rd_data | input | 8 | Array read data, one cycle after `mem_rd_en` |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out drive enable |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | ADDR_W | Array read address |
| wr_byte_valid | output | 1 | Write data byte pulse |
| wr_addr | output | ADDR_W | Captured write start address |
| wr_data | output | 8 | Write data byte |
| wr_commit | output | 1 | Start array programming |
| sr_data | output | 8 | Status byte to be written |
| sr_commit | output | 1 | Start status programming |
| wren_pulse | output | 1 | Write-enable request |
| wrdi_pulse | output | 1 | Write-disable request |
| wp_n_sync | output | 1 | Synchronised write-protect level |

## Verification
The assertions check four things on every cycle. The output stays off after the synchronised select is high. `so_data` moves only after a falling-edge event and stays frozen while paused. At most one request pulse fires in any cycle. No enable, disable or commit request follows a cycle in which the programming cycle was busy. Only the bench's scenarios can show that the data bytes are correct: the addressed bytes in order, the wrap at the top address, status values and the 0xFF substitute, the rejection of malformed opcodes, the byte-boundary rule for commits and resuming after a pause at the right bit.

// File: rtl/spi_mem_pkg.sv
// Shared opcodes, phase encoding and opcode check for the serial memory front end.
// Assumes opcodes arrive as eight bits, MSB first.
package spi_mem_pkg;

    localparam logic [2:0] OP_WRSR  = 3'b001;
    localparam logic [2:0] OP_WRITE = 3'b010;
    localparam logic [2:0] OP_READ  = 3'b011;
    localparam logic [2:0] OP_WRDI  = 3'b100;
    localparam logic [2:0] OP_RDSR  = 3'b101;
    localparam logic [2:0] OP_WREN  = 3'b110;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_DONE,
        PH_MUTE
    } phase_e;

    // True when the upper nibble is clear and the low bits name a command.
    function automatic logic opc_known(input logic [7:0] o);
        return (o[7:4] == 4'h0) && (o[2:0] != 3'b000) && (o[2:0] != 3'b111);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each pin is independent; reset loads the idle pin levels.
module spi_pin_sync #(
    parameter int              W       = 5,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    // Shift the pin values through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_edge_gate.sv
// Turns the synchronised serial clock into rise and fall events and applies the pause.
// Assumes the pause pin only changes while the serial clock is low.
module spi_edge_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sck_s,
    input  logic hold_n_s,
    output logic rise_evt,
    output logic fall_evt,
    output logic held
);

    logic sck_d;

    // Remember the previous clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Take the pause level only while the serial clock is low; clear it when deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)      held <= 1'b0;
        else if (cs_s)   held <= 1'b0;
        else if (!sck_s) held <= !hold_n_s;
    end

    assign rise_evt =  sck_s & ~sck_d & ~held & ~cs_s;
    assign fall_evt = ~sck_s &  sck_d & ~held & ~cs_s;

endmodule

// File: rtl/spi_cmd_engine.sv
// Bit sequencer, opcode decoder, address collector and read streamer.
// Assumes several system clocks between serial clock edges, and a memory with one cycle of read latency.
module spi_cmd_engine
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              si_s,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              held,
    input  logic              prog_busy,
    input  logic [7:0]        status_in,
    input  logic [7:0]        mem_rd_data,
    output logic              so_data,
    output logic              so_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              wr_byte_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic [7:0]        sr_data,
    output logic              sr_commit,
    output logic              wren_pulse,
    output logic              wrdi_pulse
);

    localparam int AFIELD = ((ADDR_W + 7) / 8) * 8;
    localparam int ACNT_W = $clog2(AFIELD);
    localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(AFIELD - 1);

    phase_e              ph;
    logic [2:0]          bcnt;
    logic [2:0]          cmd;
    logic [6:0]          sh;
    logic [ADDR_W-2:0]   ash;
    logic [ACNT_W-1:0]   acnt;
    logic [ADDR_W-1:0]   rd_ptr;
    logic [7:0]          out_sh;
    logic [7:0]          nxt_byte;
    logic [2:0]          obit;
    logic                started;
    logic                rd_pend;
    logic                byte_seen;
    logic                cs_d;
    logic [7:0]          si_word;
    logic [ADDR_W-1:0]   addr_word;
    logic [7:0]          stat_view;

    // Form the completed byte, the completed address and the visible status.
    always_comb begin
        si_word   = {sh, si_s};
        addr_word = {ash, si_s};
        stat_view = prog_busy ? 8'hFF : status_in;
    end

    // Main sequencer: shifts input bits, decodes, streams output, raises requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph            <= PH_OPC;
            bcnt          <= '0;
            cmd           <= '0;
            sh            <= '0;
            ash           <= '0;
            acnt          <= '0;
            rd_ptr        <= '0;
            out_sh        <= '0;
            nxt_byte      <= '0;
            obit          <= '0;
            started       <= 1'b0;
            rd_pend       <= 1'b0;
            byte_seen     <= 1'b0;
            cs_d          <= 1'b1;
            mem_rd_en     <= 1'b0;
            mem_rd_addr   <= '0;
            wr_byte_valid <= 1'b0;
            wr_addr       <= '0;
            wr_data       <= '0;
            wr_commit     <= 1'b0;
            sr_data       <= '0;
            sr_commit     <= 1'b0;
            wren_pulse    <= 1'b0;
            wrdi_pulse    <= 1'b0;
        end else begin
            wren_pulse    <= 1'b0;
            wrdi_pulse    <= 1'b0;
            wr_byte_valid <= 1'b0;
            wr_commit     <= 1'b0;
            sr_commit     <= 1'b0;
            mem_rd_en     <= 1'b0;
            cs_d          <= cs_s;
            rd_pend       <= mem_rd_en;
            if (cs_s) begin
                if (!cs_d && ph == PH_WDATA && bcnt == 3'd0 && byte_seen && !prog_busy) begin
                    if (cmd == OP_WRITE) wr_commit <= 1'b1;
                    else                 sr_commit <= 1'b1;
                end
                ph        <= PH_OPC;
                bcnt      <= '0;
                acnt      <= '0;
                obit      <= '0;
                started   <= 1'b0;
                byte_seen <= 1'b0;
            end else begin
                if (rise_evt) begin
                    bcnt <= bcnt + 3'd1;
                    sh   <= si_word[6:0];
                    case (ph)
                        PH_OPC: begin
                            if (bcnt == 3'd7) begin
                                cmd <= si_word[2:0];
                                if (!opc_known(si_word) ||
                                    (prog_busy && si_word[2:0] != OP_RDSR)) begin
                                    ph <= PH_MUTE;
                                end else begin
                                    case (si_word[2:0])
                                        OP_READ, OP_WRITE: begin
                                            ph   <= PH_ADDR;
                                            acnt <= '0;
                                        end
                                        OP_WREN: begin
                                            wren_pulse <= 1'b1;
                                            ph         <= PH_DONE;
                                        end
                                        OP_WRDI: begin
                                            wrdi_pulse <= 1'b1;
                                            ph         <= PH_DONE;
                                        end
                                        OP_RDSR: begin
                                            nxt_byte <= stat_view;
                                            ph       <= PH_RDATA;
                                        end
                                        default: ph <= PH_WDATA;
                                    endcase
                                end
                            end
                        end
                        PH_ADDR: begin
                            ash  <= addr_word[ADDR_W-2:0];
                            acnt <= acnt + 1'b1;
                            if (acnt == ACNT_LAST) begin
                                if (cmd == OP_READ) begin
                                    ph          <= PH_RDATA;
                                    rd_ptr      <= addr_word;
                                    mem_rd_en   <= 1'b1;
                                    mem_rd_addr <= addr_word;
                                end else begin
                                    ph      <= PH_WDATA;
                                    wr_addr <= addr_word;
                                end
                            end
                        end
                        PH_WDATA: begin
                            if (bcnt == 3'd7) begin
                                byte_seen <= 1'b1;
                                if (cmd == OP_WRITE) begin
                                    wr_byte_valid <= 1'b1;
                                    wr_data       <= si_word;
                                end else begin
                                    sr_data <= si_word;
                                end
                            end
                        end
                        default: ;
                    endcase
                end
                if (fall_evt && ph == PH_RDATA) begin
                    started <= 1'b1;
                    obit    <= obit + 3'd1;
                    if (obit == 3'd0) begin
                        out_sh <= nxt_byte;
                        if (cmd == OP_READ) begin
                            rd_ptr      <= rd_ptr + 1'b1;
                            mem_rd_en   <= 1'b1;
                            mem_rd_addr <= rd_ptr + 1'b1;
                        end else begin
                            nxt_byte <= stat_view;
                        end
                    end else begin
                        out_sh <= {out_sh[6:0], 1'b0};
                    end
                end
            end
            if (rd_pend) nxt_byte <= mem_rd_data;
        end
    end

    assign so_data = out_sh[7];
    assign so_oe   = (ph == PH_RDATA) && started && !held;

endmodule

// File: rtl/spi_mem_front.sv
// Top of the serial memory command front end: pin synchroniser, clock edge gate, command engine.
// Assumes the system clock is several times faster than the serial clock.
module spi_mem_front #(
    parameter int ADDR_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic              wp_n,
    input  logic              prog_busy,
    input  logic [7:0]        status_in,
    input  logic [7:0]        mem_rd_data,
    output logic              so_data,
    output logic              so_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic              wr_byte_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit,
    output logic [7:0]        sr_data,
    output logic              sr_commit,
    output logic              wren_pulse,
    output logic              wrdi_pulse,
    output logic              wp_n_sync
);

    localparam int NPIN = 5;
    localparam logic [NPIN-1:0] PIN_IDLE = 5'b10011;

    logic [NPIN-1:0] pin_q;
    logic cs_s, sck_s, si_s, hold_n_s;
    logic rise_evt, fall_evt, held;

    spi_pin_sync #(.W(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si, hold_n, wp_n}),
        .q     (pin_q)
    );

    assign {cs_s, sck_s, si_s, hold_n_s, wp_n_sync} = pin_q;

    spi_edge_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .sck_s    (sck_s),
        .hold_n_s (hold_n_s),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .held     (held)
    );

    spi_cmd_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_s          (cs_s),
        .si_s          (si_s),
        .rise_evt      (rise_evt),
        .fall_evt      (fall_evt),
        .held          (held),
        .prog_busy     (prog_busy),
        .status_in     (status_in),
        .mem_rd_data   (mem_rd_data),
        .so_data       (so_data),
        .so_oe         (so_oe),
        .mem_rd_en     (mem_rd_en),
        .mem_rd_addr   (mem_rd_addr),
        .wr_byte_valid (wr_byte_valid),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_commit     (wr_commit),
        .sr_data       (sr_data),
        .sr_commit     (sr_commit),
        .wren_pulse    (wren_pulse),
        .wrdi_pulse    (wrdi_pulse)
    );

endmodule

// File: rtl/spi_mem_front_chk.sv
// Cycle-by-cycle property checker for the serial memory front end, attached by bind.
// Assumes it sees the synchronised select, the pause state and the falling-edge event.
module spi_mem_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_sync,
    input logic held,
    input logic fall_evt,
    input logic prog_busy,
    input logic so_oe,
    input logic so_data,
    input logic wren_pulse,
    input logic wrdi_pulse,
    input logic wr_byte_valid,
    input logic wr_commit,
    input logic sr_commit
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sync |=> !so_oe); // R1

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_pulse, wrdi_pulse, wr_byte_valid, wr_commit, sr_commit})); // R2

    AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && $past(so_oe) && (so_data != $past(so_data))) |-> $past(fall_evt)); // R4

    AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit); // R7

    AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prog_busy) |-> !(wren_pulse || wrdi_pulse || wr_commit || sr_commit)); // R10

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> $stable(so_data)); // R11

endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_sync       (cs_s),
    .held          (held),
    .fall_evt      (fall_evt),
    .prog_busy     (prog_busy),
    .so_oe         (so_oe),
    .so_data       (so_data),
    .wren_pulse    (wren_pulse),
    .wrdi_pulse    (wrdi_pulse),
    .wr_byte_valid (wr_byte_valid),
    .wr_commit     (wr_commit),
    .sr_commit     (sr_commit)
);

// File: tb/spi_mem_front_test.sv
// Self-checking bench: opcode vector table, then directed read, write, status, busy and pause tests.
module spi_mem_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic        prog_busy = 1'b0;
    logic [7:0]  status_in = 8'h8C;
    logic [7:0]  mem_q;
    logic        so_data, so_oe, mem_rd_en, wr_byte_valid, wr_commit, sr_commit;
    logic        wren_pulse, wrdi_pulse, wp_n_sync;
    logic [14:0] mem_rd_addr, wr_addr;
    logic [7:0]  wr_data, sr_data;

    int n_chk = 0, n_err = 0;
    int c_wren = 0, c_wrdi = 0, c_wrb = 0, c_wcm = 0, c_scm = 0;
    logic [14:0] last_wa;
    logic [7:0]  last_wd, last_sd;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    spi_mem_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .wp_n(wp_n), .prog_busy(prog_busy), .status_in(status_in), .mem_rd_data(mem_q),
        .so_data(so_data), .so_oe(so_oe), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .wr_byte_valid(wr_byte_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit), .sr_data(sr_data), .sr_commit(sr_commit),
        .wren_pulse(wren_pulse), .wrdi_pulse(wrdi_pulse), .wp_n_sync(wp_n_sync)
    );

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ a[14:7] ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) if (mem_rd_en) mem_q <= pat(mem_rd_addr);

    always @(negedge clk) begin
        if (wren_pulse) c_wren++;
        if (wrdi_pulse) c_wrdi++;
        if (wr_byte_valid) begin c_wrb++; last_wa = wr_addr; last_wd = wr_data; end
        if (wr_commit) c_wcm++;
        if (sr_commit) begin c_scm++; last_sd = sr_data; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic so_s, output logic oe_s);
        si = b;
        wait_clk(6);
        so_s = so_data;
        oe_s = so_oe;
        sck = 1'b1;
        wait_clk(6);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output logic oe_any, output logic oe_all);
        logic s, o;
        oe_any = 1'b0;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(tx[i], s, o);
            rx[i] = s;
            oe_any |= o;
            oe_all &= o;
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(6);
    endtask

    task automatic desel();
        wait_clk(6);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    // Opcode vectors: {opcode, kind}; kind 0 none, 1 enable, 2 disable, 3 status read.
    localparam logic [9:0] VEC [10] = '{
        {8'h06, 2'd1}, {8'h0E, 2'd1}, {8'h04, 2'd2}, {8'h0C, 2'd2}, {8'h05, 2'd3},
        {8'h0D, 2'd3}, {8'h16, 2'd0}, {8'h07, 2'd0}, {8'h00, 2'd0}, {8'h86, 2'd0}
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rx;
        logic any_oe, all_oe, s, o;
        int w0, d0, b0, c0, q0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        // R1: reset state
        chk("R1 oe after reset", so_oe, 0);
        chk("R1 no requests after reset", c_wren + c_wrdi + c_wrb + c_wcm + c_scm, 0);

        // R2 / R3 / R9: table of opcodes
        for (int k = 0; k < 10; k++) begin
            w0 = c_wren; d0 = c_wrdi;
            sel();
            xfer(VEC[k][9:2], rx, any_oe, all_oe);
            xfer(8'h06, rx, any_oe, all_oe);
            desel();
            chk("R2 enable pulses", c_wren - w0, (VEC[k][1:0] == 2'd1) ? 1 : 0);
            chk("R2 disable pulses", c_wrdi - d0, (VEC[k][1:0] == 2'd2) ? 1 : 0);
            if (VEC[k][1:0] == 2'd3) begin
                chk("R9 status byte", rx, 8'h8C);
                chk("R9 status oe", all_oe, 1);
            end else begin
                chk("R3 output silent", any_oe, 0);
            end
        end

        // R3: after an invalid opcode, a new selection decodes normally
        w0 = c_wren;
        sel(); xfer(8'h27, rx, any_oe, all_oe); xfer(8'h06, rx, any_oe, all_oe); desel();
        chk("R3 muted until reselect", c_wren - w0, 0);
        sel(); xfer(8'h06, rx, any_oe, all_oe); desel();
        chk("R3 decode after reselect", c_wren - w0, 1);

        // R4 / R5 / R6: read with top address bit set and changing SI
        sel();
        xfer(8'h03, rx, any_oe, all_oe);
        xfer(8'h92, rx, any_oe, all_oe);
        xfer(8'h34, rx, any_oe, all_oe);
        chk("R4 oe off during address", any_oe, 0);
        for (int k = 0; k < 3; k++) begin
            xfer((k == 1) ? 8'h00 : 8'hFF, rx, any_oe, all_oe);
            chk("R4 R6 read byte", rx, pat(15'h1234 + 15'(k)));
            chk("R4 read oe", all_oe, 1);
        end
        desel();
        chk("R1 oe after deselect", so_oe, 0);

        // R5: wrap past the top address
        sel();
        xfer(8'h0B, rx, any_oe, all_oe);
        xfer(8'h7F, rx, any_oe, all_oe);
        xfer(8'hFE, rx, any_oe, all_oe);
        xfer(8'hA5, rx, any_oe, all_oe); chk("R5 byte 7FFE", rx, pat(15'h7FFE));
        xfer(8'hA5, rx, any_oe, all_oe); chk("R5 byte 7FFF", rx, pat(15'h7FFF));
        xfer(8'hA5, rx, any_oe, all_oe); chk("R5 wrap to 0000", rx, pat(15'h0000));
        desel();

        // R7: array write with two bytes
        b0 = c_wrb; c0 = c_wcm;
        sel();
        xfer(8'h02, rx, any_oe, all_oe);
        xfer(8'h81, rx, any_oe, all_oe);
        xfer(8'h40, rx, any_oe, all_oe);
        xfer(8'hA5, rx, any_oe, all_oe);
        xfer(8'h3C, rx, any_oe, all_oe);
        chk("R7 byte pulses", c_wrb - b0, 2);
        chk("R7 write address", last_wa, 15'h0140);
        chk("R7 write data", last_wd, 8'h3C);
        chk("R7 no commit before deselect", c_wcm - c0, 0);
        desel();
        chk("R7 commit on deselect", c_wcm - c0, 1);

        // R7: partial trailing byte blocks the commit
        b0 = c_wrb; c0 = c_wcm;
        sel();
        xfer(8'h02, rx, any_oe, all_oe);
        xfer(8'h02, rx, any_oe, all_oe);
        xfer(8'h00, rx, any_oe, all_oe);
        xfer(8'h11, rx, any_oe, all_oe);
        for (int i = 0; i < 4; i++) clock_bit(1'b1, s, o);
        desel();
        chk("R7 partial byte pulses", c_wrb - b0, 1);
        chk("R7 no commit off boundary", c_wcm - c0, 0);

        // R8: status write
        q0 = c_scm;
        sel(); xfer(8'h01, rx, any_oe, all_oe); xfer(8'h8C, rx, any_oe, all_oe); desel();
        chk("R8 status commit", c_scm - q0, 1);
        chk("R8 status data", last_sd, 8'h8C);

        // R9 / R10: behaviour while busy
        prog_busy = 1'b1;
        wait_clk(4);
        sel(); xfer(8'h05, rx, any_oe, all_oe); xfer(8'h00, rx, any_oe, all_oe); desel();
        chk("R9 busy status", rx, 8'hFF);
        w0 = c_wren; q0 = c_scm;
        sel(); xfer(8'h06, rx, any_oe, all_oe); desel();
        chk("R10 enable refused", c_wren - w0, 0);
        sel(); xfer(8'h01, rx, any_oe, all_oe); xfer(8'h00, rx, any_oe, all_oe); desel();
        chk("R10 status write refused", c_scm - q0, 0);
        sel();
        xfer(8'h03, rx, any_oe, all_oe); xfer(8'h00, rx, any_oe, all_oe);
        xfer(8'h10, rx, any_oe, all_oe); xfer(8'h00, rx, any_oe, all_oe);
        desel();
        chk("R10 read refused", any_oe, 0);
        prog_busy = 1'b0;
        wait_clk(4);

        // R11: pause in the middle of a read byte
        sel();
        xfer(8'h03, rx, any_oe, all_oe);
        xfer(8'h00, rx, any_oe, all_oe);
        xfer(8'h40, rx, any_oe, all_oe);
        for (int i = 7; i >= 5; i--) begin clock_bit(1'b0, s, o); rx[i] = s; end
        hold_n = 1'b0;
        wait_clk(6);
        chk("R11 oe off while paused", so_oe, 0);
        for (int i = 0; i < 3; i++) begin sck = 1'b1; wait_clk(5); sck = 1'b0; wait_clk(5); end
        chk("R11 oe off after ignored clocks", so_oe, 0);
        hold_n = 1'b1;
        wait_clk(6);
        chk("R11 oe back after resume", so_oe, 1);
        for (int i = 4; i >= 0; i--) begin clock_bit(1'b0, s, o); rx[i] = s; end
        chk("R11 byte across pause", rx, pat(15'h0040));
        xfer(8'h00, rx, any_oe, all_oe);
        chk("R11 next byte after pause", rx, pat(15'h0041));
        desel();

        // R12: write-protect level passes through
        wp_n = 1'b0;
        wait_clk(4);
        chk("R12 protect low", wp_n_sync, 0);
        wp_n = 1'b1;
        wait_clk(4);
        chk("R12 protect high", wp_n_sync, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule